// File: doc/BRIEF.md
# Condition Flag Store and Branch Decision Unit

This block keeps the four arithmetic condition flags (negative, zero, carry, overflow) of a single-cycle core in a small register. It decides whether a conditional PC-relative branch is taken and produces the address of the next instruction. The ALU supplies a fresh flag nibble on every cycle. The register takes it only on cycles where the executing instruction is a flag-setting one, so ordinary arithmetic leaves the stored flags alone.

The decode logic presents a branch strobe, a 4-bit condition code and a 19-bit word offset. The unit tests the condition against the stored flags, not against the ALU output of the current cycle. When the test passes and the strobe is high, the next PC is the current PC plus the sign-extended offset times four, which reaches about one megabyte either way. In every other case it is the current PC plus four. The decision is combinational on the register contents. A compare in one cycle therefore steers a branch in the very next cycle.

Top module: `br_unit`

## Requirements
- R1: While rst_ni is low, the flag register is cleared to 0000. After reset, EQ evaluates false, NE true, LT false and GT true.
- R2: On a rising clk_i edge with flag_we_i high, the register loads nzcv_i. Bit 3 is N, bit 2 Z, bit 1 C and bit 0 V.
- R3: On an edge with flag_we_i low, the register keeps its value whatever nzcv_i carries.
- R4: take_o is low whenever br_i is low.
- R5: Code 0000 (equal) is true when Z=1. Code 0001 (not equal) is true when Z=0.
- R6: Code 1011 (signed less) is true when N differs from V. Code 1100 (signed greater) is true when Z=0 and N equals V.
- R7: Code 1110 (always) is true for every flag value. All other eleven codes are false.
- R8: When take_o is low, pc_next_o equals pc_i + 4 modulo 2^64.
- R9: When take_o is high, pc_next_o equals pc_i plus off_i sign-extended and shifted left by two. This covers -1048576 to +1048572 bytes.
- R10: A flag value loaded on an edge governs take_o in the same cycle, right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flag_we_i | input | 1 | Current instruction sets flags |
| nzcv_i | input | 4 | Flags from the ALU, N in bit 3 |
| br_i | input | 1 | Current instruction is a conditional branch |
| cond_i | input | 4 | Condition code of the branch |
| off_i | input | 19 | Signed branch offset in words |
| pc_i | input | 64 | Address of the current instruction |
| take_o | output | 1 | Branch taken |
| pc_next_o | output | 64 | Address of the next instruction |

## Verification
The flag register is the only state, so a flag write is due one edge after it is presented. The bench drives the write after a falling edge and reads the outputs one time unit after the following rising edge. take_o and pc_next_o have no register between them and their inputs. They are due in the same cycle, so the bench samples them one time unit after changing br_i, cond_i, off_i or pc_i, with no clock edge in between. Hold behaviour is checked by letting several edges pass with the write strobe low and a different nibble on the flag input. The full condition table is then run again against the old expectation.

// File: rtl/br_pkg.sv
package br_pkg;
  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  localparam logic [3:0] CC_EQ = 4'b0000;
  localparam logic [3:0] CC_NE = 4'b0001;
  localparam logic [3:0] CC_LT = 4'b1011;
  localparam logic [3:0] CC_GT = 4'b1100;
  localparam logic [3:0] CC_AL = 4'b1110;
endpackage

// File: rtl/nzcv_reg.sv
module nzcv_reg
  import br_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   we_i,
  input  flags_t d_i,
  output flags_t q_o
);
  flags_t q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= '0;
    else if (we_i) q <= d_i;
  end

  assign q_o = q;

  // R2
  flag_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(we_i)) |-> (q == $past(d_i)));

  // R3
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(we_i)) |-> $stable(q));
endmodule

// File: rtl/cond_eval.sv
module cond_eval
  import br_pkg::*;
(
  input  flags_t     flags_i,
  input  logic [3:0] cond_i,
  input  logic       br_i,
  output logic       take_o
);
  logic hit;

  always_comb begin
    unique case (cond_i)
      CC_EQ:   hit = flags_i.z;
      CC_NE:   hit = !flags_i.z;
      CC_LT:   hit = flags_i.n ^ flags_i.v;
      CC_GT:   hit = !flags_i.z && (flags_i.n == flags_i.v);
      CC_AL:   hit = 1'b1;
      default: hit = 1'b0;
    endcase
  end

  assign take_o = br_i && hit;
endmodule

// File: rtl/pc_target.sv
module pc_target #(
  parameter int PC_W  = 64,
  parameter int IMM_W = 19
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [IMM_W-1:0] off_i,
  input  logic             take_i,
  output logic [PC_W-1:0]  pc_next_o
);
  localparam int EXT_W = PC_W - IMM_W - 2;

  logic [PC_W-1:0] off_b, tgt, seq;

  assign off_b = {{EXT_W{off_i[IMM_W-1]}}, off_i, 2'b00};
  assign tgt   = pc_i + off_b;
  assign seq   = pc_i + PC_W'(4);
  assign pc_next_o = take_i ? tgt : seq;
endmodule

// File: rtl/br_unit.sv
module br_unit
  import br_pkg::*;
#(
  parameter int PC_W  = 64,
  parameter int IMM_W = 19
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flag_we_i,
  input  logic [3:0]       nzcv_i,
  input  logic             br_i,
  input  logic [3:0]       cond_i,
  input  logic [IMM_W-1:0] off_i,
  input  logic [PC_W-1:0]  pc_i,
  output logic             take_o,
  output logic [PC_W-1:0]  pc_next_o
);
  flags_t flags;
  logic   unused_c;

  nzcv_reg u_flags (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (flag_we_i),
    .d_i   (flags_t'(nzcv_i)),
    .q_o   (flags)
  );

  assign unused_c = flags.c;

  cond_eval u_cond (
    .flags_i(flags),
    .cond_i (cond_i),
    .br_i   (br_i),
    .take_o (take_o)
  );

  pc_target #(.PC_W(PC_W), .IMM_W(IMM_W)) u_tgt (
    .pc_i     (pc_i),
    .off_i    (off_i),
    .take_i   (take_o),
    .pc_next_o(pc_next_o)
  );

  // R4
  no_br_no_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !br_i |-> !take_o);

  // R7
  always_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_i && cond_i == CC_AL) |-> take_o);

  // R8
  seq_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_o |-> (pc_next_o == pc_i + PC_W'(4)));

  // R9
  tgt_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (pc_next_o[1:0] == pc_i[1:0]));
endmodule

// File: tb/sim_br_unit.sv
module sim_br_unit;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        flag_we = 1'b0;
  logic [3:0]  nzcv = '0;
  logic        br = 1'b0;
  logic [3:0]  cond = '0;
  logic [18:0] off = '0;
  logic [63:0] pc = '0;
  logic        take;
  logic [63:0] pc_next;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  br_unit u0 (
    .clk_i(clk), .rst_ni(rst_ni), .flag_we_i(flag_we), .nzcv_i(nzcv),
    .br_i(br), .cond_i(cond), .off_i(off), .pc_i(pc),
    .take_o(take), .pc_next_o(pc_next)
  );

  function automatic bit exp_take(input logic [3:0] f, input logic [3:0] c, input bit b);
    bit n = f[3], z = f[2], v = f[0], h;
    case (c)
      4'd0:    h = z;
      4'd1:    h = !z;
      4'd11:   h = (n != v);
      4'd12:   h = !z && (n == v);
      4'd14:   h = 1'b1;
      default: h = 1'b0;
    endcase
    return b && h;
  endfunction

  function automatic logic [63:0] exp_pc(input logic [63:0] p, input logic [18:0] o, input bit t);
    longint d = longint'($signed(o)) * 4;
    return t ? p + 64'(d) : p + 64'd4;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // full table for stored flags f; requirement tag chosen per code
  task automatic sweep(input logic [3:0] f, input string tag);
    logic [18:0] offs [4] = '{19'h00000, 19'h3FFFF, 19'h40000, 19'h12345};
    for (int c = 0; c < 16; c++) begin
      for (int b = 0; b < 2; b++) begin
        bit t;
        string r;
        br = b[0]; cond = c[3:0]; off = offs[c % 4];
        pc = 64'h0000_0000_1000_0000 + 64'(f) * 64'h40;
        #1;
        t = exp_take(f, c[3:0], b[0]);
        if (b == 0) r = "R4";
        else if (c < 2) r = "R5";
        else if (c == 11 || c == 12) r = "R6";
        else r = "R7";
        chk({tag, "/", r}, 64'(take), 64'(t));
        chk(t ? "R9" : "R8", pc_next, exp_pc(pc, off, t));
      end
    end
  endtask

  initial begin
    #(PERIOD * 50000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    // R1: reset flags 0000
    br = 1'b1;
    cond = 4'd0;  #1; chk("R1 eq", 64'(take), 64'd0);
    cond = 4'd1;  #1; chk("R1 ne", 64'(take), 64'd1);
    cond = 4'd11; #1; chk("R1 lt", 64'(take), 64'd0);
    cond = 4'd12; #1; chk("R1 gt", 64'(take), 64'd1);

    for (int f = 0; f < 16; f++) begin
      @(negedge clk);
      flag_we = 1'b1; nzcv = f[3:0]; br = 1'b1; cond = 4'd0;
      @(posedge clk);
      #1;
      // R10: new flags steer the decision right after the edge
      chk("R10", 64'(take), 64'(f[2]));
      flag_we = 1'b0;
      sweep(f[3:0], "R2");
      // R3: different nibble presented with write strobe low
      nzcv = ~f[3:0];
      repeat (3) @(posedge clk);
      #1;
      sweep(f[3:0], "R3");
    end

    // R9 range limits
    br = 1'b1; cond = 4'd14; pc = 64'h0000_0000_0200_0000;
    off = 19'h3FFFF; #1; chk("R9 max", pc_next, 64'h0000_0000_020F_FFFC);
    off = 19'h40000; #1; chk("R9 min", pc_next, 64'h0000_0000_01F0_0000);
    // R8 wrap
    br = 1'b0; pc = 64'hFFFF_FFFF_FFFF_FFFC; #1; chk("R8 wrap", pc_next, 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    done = 1'b1;
    $finish;
  end
endmodule